// File: doc/BRIEF.md
# Banked Register Map with Sticky Status

This block is a byte-wide register file placed behind a simple bus target, such as the byte-level front end of a two-wire serial target. A fixed header occupies the lowest four addresses. It holds an interface version, a device status byte, a bank-select register and an error code. Every address from 4 upward is a data window, and what the window shows depends on the bank currently selected.

Bank 0 shows device identity: vendor, type, sub-type and revision, the parent's vendor, type and sub-type, a three-byte capability word and a sixteen-byte serial number. Banks 1 to N_SRC each show the last sampled value of one external source, an ADC channel or a GPI port. A new sample arrives on that source's strobe. When a strobe brings a changed value, that source's sticky flag is set. The status byte reports the OR of all such flags. Selecting a source's bank clears that source's flag.

The status byte also carries a ready indication and a two-bit self-check result. The error register is loaded on every write to the bank-select register.

Top module: `bankreg_top`

## Requirements
- R1: While reset is asserted, and until the first access afterwards, the bank register, error register, status byte and rd_data are all 0x00. Every source's held value is also 0x00.
- R2: Address 0 always reads 0x00. Writes to addresses 0, 1 and 3 have no effect on any readable byte.
- R3: Status bits 7..4 always read 0. Status bit 0 equals the ready_in value sampled at the previous clock edge.
- R4: A chk_restart clears status bits 1 and 2. A chk_done without chk_restart sets bit 1 and clears bit 2 when chk_pass is 1; it sets bit 2 and clears bit 1 when chk_pass is 0. If chk_restart and chk_done occur in the same cycle, chk_restart wins. Bits 1 and 2 are never both 1.
- R5: Address 2 reads back the last byte written to it.
- R6: Each write to address 2 loads the error register (address 3). It loads 0x00 when the written byte is 0..N_SRC, and 0x0B otherwise.
- R7: When bank 0 is selected, window offset w (address 4+w) reads as follows:
  - w 0..6: VENDOR, DEV_TYPE, DEV_SUB, DEV_REV, PAR_VENDOR, PAR_TYPE, PAR_SUB.
  - w 7..9: CAPS bytes, least significant first.
  - w 10..25: SERIAL bytes, least significant first.
- R8: When bank k (1..N_SRC) is selected, window offset 0 reads the value src_val[8(k-1)+:8] captured at the last pulse of src_stb[k-1].
- R9: A strobe of source i whose value differs from that source's held value sets source i's pending flag. A strobe with an equal value does not set it. Status bit 3 is the OR of all pending flags.
- R10: Writing k (1..N_SRC) to address 2 clears only source k-1's pending flag. A change strobe on that source in the same cycle leaves the flag set.
- R11: The following all read 0x00: window offsets beyond the selected bank's length (26 for bank 0, 1 for a source bank), and every window offset while an unimplemented bank is selected. Writes into the window change nothing.
- R12: rd_data is updated in the cycle after rd_en is sampled high, from the state before any same-cycle write. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| ready_in | input | 1 | Device ready indication |
| chk_restart | input | 1 | Self-check restart request |
| chk_done | input | 1 | Self-check completion strobe |
| chk_pass | input | 1 | Self-check result, valid with chk_done |
| src_val | input | 8*N_SRC | Sample values, one byte per source |
| src_stb | input | N_SRC | Sample strobes, one per source |

## Verification
The assertions assume three things about the inputs. First, wr_en and rd_en are single-cycle strobes whose address is stable while they are high. Second, chk_pass is only meaningful in a chk_done cycle. Third, src_val for a source is only looked at when its strobe is high. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. It issues at most one bus access per cycle, except for the deliberate collision of a bank select with a change strobe on the same source. It then sweeps all 64 addresses for every implemented bank and for an unimplemented one, comparing each byte with a model of the requirements.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int unsigned OFS_VER  = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_BANK = 2;
  localparam int unsigned OFS_ERR  = 3;
  localparam int unsigned OFS_WIN  = 4;
  localparam int unsigned ID_LEN   = 26;
  localparam int unsigned SRC_LEN  = 1;
  localparam logic [7:0]  IF_VERSION = 8'h00;
  localparam logic [7:0]  ERR_NONE   = 8'h00;
  localparam logic [7:0]  ERR_NOBANK = 8'h0B;
endpackage

// File: rtl/bankreg_status.sv
module bankreg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  input  logic chk_restart,
  input  logic chk_done,
  input  logic chk_pass,
  output logic ready_q,
  output logic pass_q,
  output logic fail_q
);
  logic ready_d, pass_d, fail_d;

  always_comb begin
    ready_d = ready_in;
    pass_d  = pass_q;
    fail_d  = fail_q;
    if (chk_restart) begin
      pass_d = 1'b0;
      fail_d = 1'b0;
    end else if (chk_done) begin
      pass_d = chk_pass;
      fail_d = !chk_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  // R4
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_restart |=> (!pass_q && !fail_q));
  // R4
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && !chk_restart) |=> ($countones({pass_q, fail_q}) == 1 && pass_q == $past(chk_pass)));
  // R4
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q));
  // R3
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ready_q == $past(ready_in)));
endmodule

// File: rtl/bankreg_src.sv
module bankreg_src (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic [7:0] val,
  input  logic       sel_hit,
  output logic [7:0] held_q,
  output logic       pend_q
);
  logic [7:0] held_d;
  logic       pend_d;
  logic       change;

  always_comb begin
    change = stb && (val != held_q);
    held_d = stb ? val : held_q;
    if (change)       pend_d = 1'b1;
    else if (sel_hit) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 8'h00;
      pend_q <= 1'b0;
    end else begin
      held_q <= held_d;
      pend_q <= pend_d;
    end
  end

  // R9
  change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && val != held_q) |=> pend_q);
  // R10
  select_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !(stb && val != held_q)) |=> !pend_q);
  // R8
  sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (held_q == $past(val)));
endmodule

// File: rtl/bankreg_rdmux.sv
module bankreg_rdmux
  import bankreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned N_SRC      = 3,
  parameter logic [7:0]  VENDOR     = 8'h5A,
  parameter logic [7:0]  DEV_TYPE   = 8'h21,
  parameter logic [7:0]  DEV_SUB    = 8'h03,
  parameter logic [7:0]  DEV_REV    = 8'h07,
  parameter logic [7:0]  PAR_VENDOR = 8'h00,
  parameter logic [7:0]  PAR_TYPE   = 8'h10,
  parameter logic [7:0]  PAR_SUB    = 8'h01,
  parameter logic [23:0] CAPS       = 24'hC0FFEE,
  parameter logic [127:0] SERIAL    = 128'h0123456789ABCDEFFEDCBA9876543210
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         status,
  input  logic [7:0]         bank_sel,
  input  logic [7:0]         err,
  input  logic [8*N_SRC-1:0] held_flat,
  output logic [7:0]         data
);
  logic [ADDR_W-1:0] w;
  int unsigned       wi;
  logic [7:0]        id_byte, src_byte;

  always_comb begin
    w  = addr - ADDR_W'(OFS_WIN);
    wi = 32'(w);
    id_byte = 8'h00;
    case (wi)
      0: id_byte = VENDOR;
      1: id_byte = DEV_TYPE;
      2: id_byte = DEV_SUB;
      3: id_byte = DEV_REV;
      4: id_byte = PAR_VENDOR;
      5: id_byte = PAR_TYPE;
      6: id_byte = PAR_SUB;
      default: id_byte = 8'h00;
    endcase
    for (int k = 0; k < 3; k++)
      if (wi == 32'(7 + k)) id_byte = CAPS[8*k +: 8];
    for (int k = 0; k < 16; k++)
      if (wi == 32'(10 + k)) id_byte = SERIAL[8*k +: 8];
    src_byte = 8'h00;
    for (int i = 0; i < N_SRC; i++)
      if (bank_sel == 8'(i + 1) && wi < SRC_LEN) src_byte = held_flat[8*i +: 8];
  end

  always_comb begin
    if (addr == ADDR_W'(OFS_VER))       data = IF_VERSION;
    else if (addr == ADDR_W'(OFS_STAT)) data = status;
    else if (addr == ADDR_W'(OFS_BANK)) data = bank_sel;
    else if (addr == ADDR_W'(OFS_ERR))  data = err;
    else if (bank_sel == 8'h00)         data = id_byte;
    else                                data = src_byte;
  end
endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
  import bankreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned N_SRC      = 3,
  parameter logic [7:0]  VENDOR     = 8'h5A,
  parameter logic [7:0]  DEV_TYPE   = 8'h21,
  parameter logic [7:0]  DEV_SUB    = 8'h03,
  parameter logic [7:0]  DEV_REV    = 8'h07,
  parameter logic [7:0]  PAR_VENDOR = 8'h00,
  parameter logic [7:0]  PAR_TYPE   = 8'h10,
  parameter logic [7:0]  PAR_SUB    = 8'h01,
  parameter logic [23:0] CAPS       = 24'hC0FFEE,
  parameter logic [127:0] SERIAL    = 128'h0123456789ABCDEFFEDCBA9876543210
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  input  logic               ready_in,
  input  logic               chk_restart,
  input  logic               chk_done,
  input  logic               chk_pass,
  input  logic [8*N_SRC-1:0] src_val,
  input  logic [N_SRC-1:0]   src_stb
);
  localparam logic [7:0] MAX_BANK = 8'(N_SRC);

  logic       rst_meta, rst_q;
  logic [7:0] bank_q, bank_d, err_q, err_d, rd_d, status, mux_out;
  logic       bank_wr;
  logic       ready_q, pass_q, fail_q;
  logic [N_SRC-1:0]   sel_hit, pend;
  logic [8*N_SRC-1:0] held_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bankreg_status u_status (
    .clk(clk), .rst_n(rst_q), .ready_in(ready_in), .chk_restart(chk_restart),
    .chk_done(chk_done), .chk_pass(chk_pass),
    .ready_q(ready_q), .pass_q(pass_q), .fail_q(fail_q)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign sel_hit[i] = bank_wr && (wr_data == 8'(i + 1));
    bankreg_src u_src (
      .clk(clk), .rst_n(rst_q), .stb(src_stb[i]), .val(src_val[8*i +: 8]),
      .sel_hit(sel_hit[i]), .held_q(held_flat[8*i +: 8]), .pend_q(pend[i])
    );
  end

  assign status = {4'b0000, |pend, fail_q, pass_q, ready_q};

  bankreg_rdmux #(
    .ADDR_W(ADDR_W), .N_SRC(N_SRC), .VENDOR(VENDOR), .DEV_TYPE(DEV_TYPE),
    .DEV_SUB(DEV_SUB), .DEV_REV(DEV_REV), .PAR_VENDOR(PAR_VENDOR),
    .PAR_TYPE(PAR_TYPE), .PAR_SUB(PAR_SUB), .CAPS(CAPS), .SERIAL(SERIAL)
  ) u_rdmux (
    .addr(addr), .status(status), .bank_sel(bank_q), .err(err_q),
    .held_flat(held_flat), .data(mux_out)
  );

  always_comb begin
    bank_wr = wr_en && (addr == ADDR_W'(OFS_BANK));
    bank_d  = bank_wr ? wr_data : bank_q;
    err_d   = err_q;
    if (bank_wr) err_d = (wr_data <= MAX_BANK) ? ERR_NONE : ERR_NOBANK;
    rd_d    = rd_en ? mux_out : rd_data;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bank_q  <= 8'h00;
      err_q   <= 8'h00;
      rd_data <= 8'h00;
    end else begin
      bank_q  <= bank_d;
      err_q   <= err_d;
      rd_data <= rd_d;
    end
  end

  // R6
  err_update_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == ADDR_W'(OFS_BANK)) |=>
      (err_q == (($past(wr_data) <= MAX_BANK) ? ERR_NONE : ERR_NOBANK)));
  // R2
  version_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && addr == ADDR_W'(OFS_VER)) |=> (rd_data == 8'h00));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> $stable(rd_data));
  // R3
  status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && addr == ADDR_W'(OFS_STAT)) |=> (rd_data[7:4] == 4'h0));
endmodule

// File: tb/bankreg_top_tb.sv
module bankreg_top_tb;
  localparam int AW = 6;
  localparam int NS = 3;
  localparam logic [7:0] ID_B [0:6] = '{8'h5A, 8'h21, 8'h03, 8'h07, 8'h00, 8'h10, 8'h01};
  localparam logic [23:0]  CAPS_V   = 24'hC0FFEE;
  localparam logic [127:0] SERIAL_V = 128'h0123456789ABCDEFFEDCBA9876543210;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0, ready_in = 0, chk_restart = 0, chk_done = 0, chk_pass = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [8*NS-1:0] src_val = '0;
  logic [NS-1:0] src_stb = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] m_sel = 0, m_err = 0;
  logic m_ready = 0, m_pass = 0, m_fail = 0;
  logic [7:0] m_held [NS];
  logic m_pend [NS];

  always #5 clk = ~clk;

  bankreg_top #(.ADDR_W(AW), .N_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ready_in(ready_in), .chk_restart(chk_restart),
    .chk_done(chk_done), .chk_pass(chk_pass), .src_val(src_val), .src_stb(src_stb)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    logic any = 0;
    for (int i = 0; i < NS; i++) any |= m_pend[i];
    return {4'h0, any, m_fail, m_pass, m_ready};
  endfunction

  function automatic logic [7:0] m_byte(int a);
    int w = a - 4;
    case (a)
      0: return 8'h00;
      1: return m_status();
      2: return m_sel;
      3: return m_err;
      default: ;
    endcase
    if (m_sel == 0) begin
      if (w < 7) return ID_B[w];
      if (w < 10) return CAPS_V[8*(w-7) +: 8];
      if (w < 26) return SERIAL_V[8*(w-10) +: 8];
      return 8'h00;
    end
    if (m_sel <= NS && w == 0) return m_held[m_sel-1];
    return 8'h00;
  endfunction

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk); addr = AW'(a); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a == 2) begin
      m_sel = d;
      m_err = (d <= NS) ? 8'h00 : 8'h0B;
      if (d >= 1 && d <= NS) m_pend[d-1] = 0;
    end
  endtask

  task automatic bus_read(int a, string tag);
    @(negedge clk); addr = AW'(a); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(tag, rd_data, m_byte(a));
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 64; a++) bus_read(a, tag);
  endtask

  task automatic strobe(int i, logic [7:0] v);
    @(negedge clk); src_val[8*i +: 8] = v; src_stb[i] = 1;
    @(negedge clk); src_stb[i] = 0;
    if (v != m_held[i]) m_pend[i] = 1;
    m_held[i] = v;
  endtask

  task automatic selfcheck(bit rs, bit dn, bit ps);
    @(negedge clk); chk_restart = rs; chk_done = dn; chk_pass = ps;
    @(negedge clk); chk_restart = 0; chk_done = 0;
    if (rs) begin m_pass = 0; m_fail = 0; end
    else if (dn) begin m_pass = ps; m_fail = !ps; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_held[i] = 0; m_pend[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", rd_data, 8'h00);
    sweep("R1 R7 reset and bank0 map");

    // R3 ready follows input
    @(negedge clk); ready_in = 1; m_ready = 1;
    bus_read(1, "R3 ready set");
    // R4 self-check sequences
    selfcheck(0, 1, 1); bus_read(1, "R4 pass");
    selfcheck(0, 1, 0); bus_read(1, "R4 fail");
    selfcheck(1, 0, 0); bus_read(1, "R4 restart");
    selfcheck(0, 1, 0); selfcheck(1, 1, 1); bus_read(1, "R4 restart wins");
    @(negedge clk); ready_in = 0; m_ready = 0;

    // R2 ignored header writes
    bus_write(0, 8'hFF); bus_write(1, 8'hFF); bus_write(3, 8'hFF);
    bus_read(0, "R2 version"); bus_read(1, "R2 status"); bus_read(3, "R2 error");

    // R8 R9 samples and pending
    strobe(0, 8'h3C); bus_read(1, "R9 change sets");
    strobe(2, 8'h99); strobe(1, 8'h00); bus_read(1, "R9 equal value");
    for (int b = 0; b <= NS + 1; b++) begin
      bus_write(2, 8'(b));
      bus_read(2, "R5 bank readback");
      bus_read(3, "R6 error");
      bus_read(1, "R10 select clears own");
      sweep("R8 R11 window sweep");
    end
    bus_write(2, 8'd200); sweep("R6 R11 invalid bank");

    // R10 only own flag, collision
    strobe(0, 8'h11); strobe(1, 8'h22);
    bus_write(2, 8'd1); bus_read(1, "R10 other flag kept");
    @(negedge clk); addr = 2; wr_data = 8'd2; wr_en = 1; src_val[15:8] = 8'h23; src_stb[1] = 1;
    @(negedge clk); wr_en = 0; src_stb[1] = 0;
    m_sel = 2; m_err = 0; m_held[1] = 8'h23; m_pend[1] = 1;
    bus_read(1, "R10 collision set wins");
    bus_write(2, 8'd2); bus_read(1, "R10 cleared");

    // R11 window write ignored
    bus_write(4, 8'hAB); bus_read(4, "R11 window write");
    // R12 hold
    bus_read(4, "R12 read");
    @(negedge clk); addr = 2;
    repeat (2) @(negedge clk);
    check("R12 hold", rd_data, m_held[1]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule